// File: doc/BRIEF.md
# Framed Serial Byte Command Router

This block sits downstream of a serial receiver and decides, for every received byte, what the byte is. A byte is presented with a one-cycle valid strobe and is dealt with in that same cycle; the block never waits for a later byte. Letters from a fixed command set go straight into a small command FIFO as one-byte command codes. A start character opens a framed string. The bytes that follow are collected into a string buffer until a terminator closes the frame. The terminator then places a string-complete code in the command FIFO. All other bytes are thrown away.

A consumer drains the command FIFO with a pop strobe. When it sees the string-complete code, it reads the held string through an address port and releases it with an acknowledge. While a string is held, the buffer and its length stay frozen. A frame that tries to open during that time is refused and counted. A frame that grows past its maximum length is abandoned. When the command FIFO is full, any further command is lost and a sticky overflow flag is raised.

Top module: `cmd_frame_router`

## Requirements
- R1: After reset, cmdEmpty is 1, strValid is 0, cmdOverflow is 0 and frameDropCount is 0.
- R2: With no frame open, a byte from 0x41 to 0x5A is pushed into the command FIFO with its own value. It is visible on cmdData one cycle after the strobe. Commands leave in arrival order, and each cmdRdEn pulse removes the oldest one.
- R3: With no frame open, a byte that is not a command byte and is not 0x24 is dropped and leaves the command FIFO unchanged. This includes the terminator 0x0A.
- R4: With no frame open and no string held, 0x24 opens a frame. Every later byte other than 0x24 and 0x0A, command letters included, is stored at consecutive buffer addresses starting at 0 and is not pushed as a command.
- R5: 0x0A inside a frame closes the frame, pushes code 0xFF into the command FIFO, sets strValid and reports the number of stored bytes on strLen.
- R6: 0x24 inside a frame restarts it: the stored length goes back to zero and the following bytes are stored from address 0.
- R7: A frame holds at most 96 bytes. A 97th data byte abandons the frame without pushing 0xFF, and the next bytes are treated as outside any frame.
- R8: A held string keeps strValid, strLen and the buffer contents unchanged until strAck, which clears strValid.
- R9: 0x24 arriving while a string is held and no frame is open opens no frame and increments frameDropCount (8 bits, wrapping). The following bytes are handled as outside a frame.
- R10: With the FIFO at its depth of 8, a further push is dropped, cmdOverflow is set and stays set until reset, and the 8 stored commands are kept.
- R11: Exactly one byte is handled per rxValid strobe. With rxValid low, rxByte has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxValid | input | 1 | One-cycle strobe for a received byte |
| rxByte | input | 8 | Received byte |
| cmdRdEn | input | 1 | Pops the oldest command |
| cmdData | output | 8 | Oldest command code (shown ahead of the pop) |
| cmdEmpty | output | 1 | Command FIFO is empty |
| cmdOverflow | output | 1 | Sticky flag: a command was lost because the FIFO was full |
| strValid | output | 1 | A completed string is being held |
| strLen | output | 7 | Length of the held string |
| strRdAddr | input | 7 | String buffer read address |
| strRdData | output | 8 | Byte at strRdAddr, 0 beyond the buffer |
| strAck | input | 1 | Releases the held string |
| frameDropCount | output | 8 | Number of frames refused while a string was held |

## Verification
The bench sends every one of the 256 byte values with no frame open. This separates the command range, the dropped bytes and the start character, and it shows whether the range edges 0x40, 0x41, 0x5A and 0x5B fall on the correct side. Short frames that contain command letters and digits show that bytes inside a frame are stored and not routed as commands. A restart in mid-frame shows that the length goes back to zero. Frames of exactly 96 and 97 bytes pin down the length limit from both sides. A start character sent while a string is held, and nine commands pushed into the eight-entry FIFO, show that those two losses are reported and that the stored data stays intact.

// File: rtl/cmd_frame_router_pkg.sv
package cmd_frame_router_pkg;
  localparam int BYTE_W = 8;

  // strobes from control to datapath for one handled byte
  typedef struct packed {
    logic              pushCmd;
    logic [BYTE_W-1:0] pushCode;
    logic              storeByte;
    logic [BYTE_W-1:0] storeData;
  } ctrlStrobe_t;
endpackage

// File: rtl/cfr_ctrl.sv
module cfr_ctrl
  import cmd_frame_router_pkg::*;
#(
  parameter int            MAX_LEN  = 96,
  parameter logic [7:0]    START_CH = 8'h24,
  parameter logic [7:0]    TERM_CH  = 8'h0A,
  parameter logic [7:0]    CMD_LO   = 8'h41,
  parameter logic [7:0]    CMD_HI   = 8'h5A,
  parameter logic [7:0]    DONE_CODE = 8'hFF,
  localparam int           LEN_W    = $clog2(MAX_LEN + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxValid,
  input  logic [7:0]        rxByte,
  input  logic              strAck,
  output ctrlStrobe_t       strobe,
  output logic [LEN_W-1:0]  storeAddr,
  output logic              inFrame,
  output logic              strValid,
  output logic [LEN_W-1:0]  strLen,
  output logic [7:0]        frameDropCount
);
  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MAX_LEN);

  logic [LEN_W-1:0] frameLen;
  logic isStart, isTerm, isCmd;

  assign isStart   = (rxByte == START_CH);
  assign isTerm    = (rxByte == TERM_CH);
  assign isCmd     = (rxByte >= CMD_LO) && (rxByte <= CMD_HI);
  assign storeAddr = frameLen;

  always_comb begin
    strobe = '0;
    if (rxValid) begin
      if (inFrame) begin
        if (isTerm) begin
          strobe.pushCmd  = 1'b1;
          strobe.pushCode = DONE_CODE;
        end else if (!isStart && frameLen != LEN_MAX) begin
          strobe.storeByte = 1'b1;
          strobe.storeData = rxByte;
        end
      end else if (isCmd) begin
        strobe.pushCmd  = 1'b1;
        strobe.pushCode = rxByte;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inFrame        <= 1'b0;
      frameLen       <= '0;
      strValid       <= 1'b0;
      strLen         <= '0;
      frameDropCount <= '0;
    end else begin
      if (strAck) strValid <= 1'b0;
      if (rxValid) begin
        if (inFrame) begin
          if (isStart) begin
            frameLen <= '0;
          end else if (isTerm) begin
            inFrame  <= 1'b0;
            strValid <= 1'b1;
            strLen   <= frameLen;
          end else if (frameLen == LEN_MAX) begin
            inFrame  <= 1'b0;
            frameLen <= '0;
          end else begin
            frameLen <= frameLen + 1'b1;
          end
        end else if (isStart) begin
          if (strValid) begin
            frameDropCount <= frameDropCount + 1'b1;
          end else begin
            inFrame  <= 1'b1;
            frameLen <= '0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/cfr_dpath.sv
module cfr_dpath
  import cmd_frame_router_pkg::*;
#(
  parameter int  FIFO_DEPTH = 8,
  parameter int  MAX_LEN    = 96,
  localparam int PTR_W      = $clog2(FIFO_DEPTH),
  localparam int CNT_W      = $clog2(FIFO_DEPTH + 1),
  localparam int LEN_W      = $clog2(MAX_LEN + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobe,
  input  logic [LEN_W-1:0] storeAddr,
  input  logic             cmdRdEn,
  output logic [7:0]       cmdData,
  output logic             cmdEmpty,
  output logic             cmdOverflow,
  input  logic [LEN_W-1:0] strRdAddr,
  output logic [7:0]       strRdData
);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(FIFO_DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FIFO_DEPTH);

  logic [7:0]       fifoMem [FIFO_DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] fillCnt;
  logic             fifoFull, doPush, doPop;

  logic [7:0]       strMem [MAX_LEN];

  assign fifoFull = (fillCnt == CNT_FULL);
  assign cmdEmpty = (fillCnt == '0);
  assign doPush   = strobe.pushCmd && !fifoFull;
  assign doPop    = cmdRdEn && !cmdEmpty;
  assign cmdData  = fifoMem[rdPtr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr       <= '0;
      rdPtr       <= '0;
      fillCnt     <= '0;
      cmdOverflow <= 1'b0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == PTR_LAST) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == PTR_LAST) ? '0 : rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   fillCnt <= fillCnt + 1'b1;
        2'b01:   fillCnt <= fillCnt - 1'b1;
        default: fillCnt <= fillCnt;
      endcase
      if (strobe.pushCmd && fifoFull) cmdOverflow <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) fifoMem[wrPtr] <= strobe.pushCode;
  end

  always_ff @(posedge clk) begin
    if (strobe.storeByte && storeAddr < LEN_W'(MAX_LEN))
      strMem[storeAddr] <= strobe.storeData;
  end

  always_comb begin
    strRdData = '0;
    if (strRdAddr < LEN_W'(MAX_LEN)) strRdData = strMem[strRdAddr];
  end
endmodule

// File: rtl/cmd_frame_router.sv
module cmd_frame_router
  import cmd_frame_router_pkg::*;
#(
  parameter int  FIFO_DEPTH = 8,
  parameter int  MAX_LEN    = 96,
  localparam int LEN_W      = $clog2(MAX_LEN + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxValid,
  input  logic [7:0]       rxByte,
  input  logic             cmdRdEn,
  output logic [7:0]       cmdData,
  output logic             cmdEmpty,
  output logic             cmdOverflow,
  output logic             strValid,
  output logic [LEN_W-1:0] strLen,
  input  logic [LEN_W-1:0] strRdAddr,
  output logic [7:0]       strRdData,
  input  logic             strAck,
  output logic [7:0]       frameDropCount
);
  ctrlStrobe_t      strobe;
  logic [LEN_W-1:0] storeAddr;
  logic             inFrame;

  cfr_ctrl #(.MAX_LEN(MAX_LEN)) u_ctrl (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxByte(rxByte),
    .strAck(strAck), .strobe(strobe), .storeAddr(storeAddr),
    .inFrame(inFrame), .strValid(strValid), .strLen(strLen),
    .frameDropCount(frameDropCount)
  );

  cfr_dpath #(.FIFO_DEPTH(FIFO_DEPTH), .MAX_LEN(MAX_LEN)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .storeAddr(storeAddr),
    .cmdRdEn(cmdRdEn), .cmdData(cmdData), .cmdEmpty(cmdEmpty),
    .cmdOverflow(cmdOverflow), .strRdAddr(strRdAddr), .strRdData(strRdData)
  );
endmodule

// File: rtl/cfr_checker.sv
module cfr_checker #(
  parameter int LEN_W = 7
) (
  input logic             clk,
  input logic             rstN,
  input logic             rxValid,
  input logic [7:0]       rxByte,
  input logic             cmdRdEn,
  input logic             cmdEmpty,
  input logic             cmdOverflow,
  input logic             strValid,
  input logic [LEN_W-1:0] strLen,
  input logic             strAck,
  input logic [7:0]       frameDropCount,
  input logic             inFrame
);
  // R5: a terminator inside a frame closes it and holds the string
  a_r5_term_closes: assert property (@(posedge clk) disable iff (!rstN)
    inFrame && rxValid && rxByte == 8'h0A |=> strValid && !inFrame);

  // R5: closing a frame puts a command into the FIFO
  a_r5_term_pushes: assert property (@(posedge clk) disable iff (!rstN)
    inFrame && rxValid && rxByte == 8'h0A |=> !cmdEmpty);

  // R8: a held string stays frozen until acknowledged
  a_r8_frozen: assert property (@(posedge clk) disable iff (!rstN)
    strValid && !strAck |=> strValid && $stable(strLen));

  // R4: a frame never opens while a string is held
  a_r4_no_frame_while_held: assert property (@(posedge clk) disable iff (!rstN)
    !(inFrame && strValid));

  // R9: a refused frame bumps the drop count
  a_r9_drop_counted: assert property (@(posedge clk) disable iff (!rstN)
    !inFrame && strValid && rxValid && rxByte == 8'h24 |=>
      frameDropCount == $past(frameDropCount) + 8'd1 && !inFrame);

  // R10: overflow flag is sticky
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rstN)
    cmdOverflow |=> cmdOverflow);

  // R11: without a strobe the frame state and drop count do not move
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !rxValid |=> $stable(inFrame) && $stable(frameDropCount));

  // R2: a command byte outside a frame leaves the FIFO non-empty
  a_r2_cmd_pushed: assert property (@(posedge clk) disable iff (!rstN)
    !inFrame && rxValid && rxByte >= 8'h41 && rxByte <= 8'h5A && !cmdRdEn
      |=> !cmdEmpty);
endmodule

bind cmd_frame_router cfr_checker #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxByte(rxByte),
  .cmdRdEn(cmdRdEn), .cmdEmpty(cmdEmpty), .cmdOverflow(cmdOverflow),
  .strValid(strValid), .strLen(strLen), .strAck(strAck),
  .frameDropCount(frameDropCount), .inFrame(inFrame)
);

// File: tb/tb_cmd_frame_router.sv
`timescale 1ns/1ps
module tb_cmd_frame_router;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxValid = 1'b0;
  logic [7:0] rxByte = 8'h00;
  logic       cmdRdEn = 1'b0;
  logic [7:0] cmdData;
  logic       cmdEmpty, cmdOverflow, strValid;
  logic [6:0] strLen;
  logic [6:0] strRdAddr = 7'd0;
  logic [7:0] strRdData;
  logic       strAck = 1'b0;
  logic [7:0] frameDropCount;

  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;

  cmd_frame_router dut (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxByte(rxByte),
    .cmdRdEn(cmdRdEn), .cmdData(cmdData), .cmdEmpty(cmdEmpty),
    .cmdOverflow(cmdOverflow), .strValid(strValid), .strLen(strLen),
    .strRdAddr(strRdAddr), .strRdData(strRdData), .strAck(strAck),
    .frameDropCount(frameDropCount)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sendByte(input logic [7:0] b);
    @(negedge clk); rxValid = 1'b1; rxByte = b;
    @(negedge clk); rxValid = 1'b0; rxByte = 8'h00;
  endtask

  task automatic popExpect(input logic [7:0] exp, input string req);
    check(!cmdEmpty, req, cmdEmpty, 0);
    check(cmdData == exp, req, cmdData, exp);
    @(negedge clk); cmdRdEn = 1'b1;
    @(negedge clk); cmdRdEn = 1'b0;
  endtask

  task automatic ackString();
    @(negedge clk); strAck = 1'b1;
    @(negedge clk); strAck = 1'b0;
  endtask

  task automatic readExpect(input int addr, input logic [7:0] exp, input string req);
    strRdAddr = 7'(addr);
    #1;
    check(strRdData == exp, req, strRdData, exp);
  endtask

  function automatic logic [7:0] patByte(input int i);
    return 8'h30 + 8'(i % 64);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(cmdEmpty == 1'b1, "R1 empty", cmdEmpty, 1);
    check(strValid == 1'b0, "R1 strValid", strValid, 0);
    check(cmdOverflow == 1'b0, "R1 overflow", cmdOverflow, 0);
    check(frameDropCount == 8'd0, "R1 dropCount", frameDropCount, 0);

    // R11: bytes without strobe are ignored
    @(negedge clk); rxByte = 8'h41;
    repeat (4) @(negedge clk);
    rxByte = 8'h24;
    repeat (2) @(negedge clk);
    rxByte = 8'h00;
    check(cmdEmpty, "R11 no strobe", cmdEmpty, 1);
    sendByte(8'h0A);
    check(cmdEmpty && !strValid, "R11 no frame opened", strValid, 0);

    // exhaustive sweep with no frame open: R2, R3, R4, R5
    for (int b = 0; b < 256; b++) begin
      sendByte(8'(b));
      if (b == 8'h24) begin
        check(cmdEmpty, "R4 start pushes nothing", cmdEmpty, 1);
        sendByte(8'h0A);
        popExpect(8'hFF, "R5 empty frame code");
        check(strValid && strLen == 7'd0, "R5 empty frame len", strLen, 0);
        ackString();
        check(!strValid, "R8 ack clears", strValid, 0);
      end else if (b >= 8'h41 && b <= 8'h5A) begin
        popExpect(8'(b), "R2 command byte");
        check(cmdEmpty, "R2 single push", cmdEmpty, 1);
      end else begin
        check(cmdEmpty, "R3 dropped byte", b, -1);
      end
    end

    // R4/R5: frame with letters and digits
    sendByte(8'h24);
    sendByte(8'h41); sendByte(8'h42); sendByte(8'h31); sendByte(8'h7A);
    check(cmdEmpty, "R4 letters stored not pushed", cmdEmpty, 1);
    sendByte(8'h0A);
    check(strValid && strLen == 7'd4, "R5 length", strLen, 4);
    readExpect(0, 8'h41, "R4 byte0");
    readExpect(1, 8'h42, "R4 byte1");
    readExpect(2, 8'h31, "R4 byte2");
    readExpect(3, 8'h7A, "R4 byte3");
    popExpect(8'hFF, "R5 done code");

    // R8 frozen while held, R9 refused frame
    repeat (5) @(negedge clk);
    check(strValid && strLen == 7'd4, "R8 held length", strLen, 4);
    sendByte(8'h24);
    check(frameDropCount == 8'd1, "R9 drop count", frameDropCount, 1);
    sendByte(8'h43);
    popExpect(8'h43, "R9 next byte outside frame");
    readExpect(0, 8'h41, "R8 buffer intact");
    check(strLen == 7'd4, "R8 length intact", strLen, 4);
    ackString();

    // R6 restart in mid-frame
    sendByte(8'h24);
    sendByte(8'h51); sendByte(8'h52); sendByte(8'h53);
    sendByte(8'h24);
    sendByte(8'h61); sendByte(8'h62);
    sendByte(8'h0A);
    check(strLen == 7'd2, "R6 restart length", strLen, 2);
    readExpect(0, 8'h61, "R6 restart data");
    popExpect(8'hFF, "R6 done code");
    ackString();

    // R7 exactly 96 bytes accepted
    sendByte(8'h24);
    for (int i = 0; i < 96; i++) sendByte(patByte(i));
    sendByte(8'h0A);
    check(strValid && strLen == 7'd96, "R7 full length", strLen, 96);
    readExpect(0, patByte(0), "R7 first");
    readExpect(95, patByte(95), "R7 last");
    popExpect(8'hFF, "R7 full frame code");
    ackString();

    // R7 97 bytes abandon
    sendByte(8'h24);
    for (int i = 0; i < 97; i++) sendByte(patByte(i + 5));
    check(cmdEmpty && !strValid, "R7 abandoned", strValid, 0);
    sendByte(8'h51);
    popExpect(8'h51, "R7 back outside frame");
    sendByte(8'h0A);
    check(cmdEmpty && !strValid, "R7 stray terminator", strValid, 0);

    // R10 overflow
    for (int i = 0; i < 9; i++) sendByte(8'h41 + 8'(i));
    check(cmdOverflow, "R10 overflow set", cmdOverflow, 1);
    for (int i = 0; i < 8; i++) popExpect(8'h41 + 8'(i), "R10 kept order");
    check(cmdEmpty, "R10 ninth lost", cmdEmpty, 1);
    repeat (3) @(negedge clk);
    check(cmdOverflow, "R10 sticky", cmdOverflow, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule